// File: doc/BRIEF.md
# Staggered Half-Word Pipelined Adder

This block is a 32-bit add/subtract unit that is cut into three consecutive fast-clock phases instead of one wide carry chain. The first phase forms the low half-word of the result. The second phase forms the high half-word from the carry that the low half produced. The third phase derives the condition flags. Each half-word is registered as soon as it is known. The low half of every result is also driven out one phase after issue, so a neighbour such as a cache index path can start early.

A dependent operation does not wait for its producer's whole 32-bit result. Each operand has a bypass enable and a source tag. When the tag matches an operation still in flight, the low half of the operand is taken from that producer's phase-1 register. The high half is taken one phase later from the producer's phase-2 register. Because of this, a chain of dependent adds can issue one per phase. A stall input freezes all three phases together, so the distances between producers and consumers are kept.

Top module: `stag_adder`

## Requirements
- R1: After synchronous reset, `lo_valid_o` and `res_valid_o` are 0.
- R2: An operation accepted at a clock edge shows its low 16 result bits on `lo_sum_o`, with `lo_valid_o` = 1 and its tag on `lo_dst_o`, after that edge. The same bits appear as `res_sum_o[15:0]` two unstalled cycles later.
- R3: With `issue_sub_i` = 0, `res_sum_o` is (A + B) mod 2^32, and `res_valid_o`/`res_dst_o` carry the operation's valid bit and tag. Both appear three unstalled cycles after acceptance, and the carry from bit 15 reaches bit 16.
- R4: With `issue_sub_i` = 1, `res_sum_o` is (A − B) mod 2^32, formed as A + ~B + 1.
- R5: `res_flags_o[1]` (carry) is the carry out of bit 31 of A + B' + cin, where B' is B or ~B and cin is `issue_sub_i`. For a subtract, 1 means no borrow.
- R6: `res_flags_o[0]` (zero) is 1 exactly when all 32 result bits are 0. It is not 1 when only one half is zero.
- R7: `res_flags_o[2]` (sign) equals result bit 31.
- R8: `res_flags_o[3]` (overflow) is 1 when A[31] equals B'[31] and result bit 31 differs from A[31].
- R9: If an operand's bypass enable is 1 and its tag equals the destination tag of the valid operation in the slot just before it, that operand is replaced by that operation's full 32-bit result.
- R10: If there is no distance-one match, a match with the valid operation two slots earlier supplies the operand. Bubbles count as slots.
- R11: When both earlier slots match, the nearer (distance one) producer wins.
- R12: While `stall_i` = 1, every stage and all outputs hold, and the issue inputs are ignored. Bypass distances are measured in unstalled cycles.
- R13: With the bypass enable 0, or with no valid matching producer, the operand comes from its data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze all phases |
| issue_valid_i | input | 1 | New operation present |
| issue_sub_i | input | 1 | 1 = subtract, 0 = add |
| issue_dst_i | input | TAG_W | Destination tag of the operation |
| opa_i | input | DATA_W | Operand A value from port |
| opa_byp_i | input | 1 | Allow bypass for A |
| opa_tag_i | input | TAG_W | Source tag of A |
| opb_i | input | DATA_W | Operand B value from port |
| opb_byp_i | input | 1 | Allow bypass for B |
| opb_tag_i | input | TAG_W | Source tag of B |
| lo_valid_o | output | 1 | Early low half is valid |
| lo_dst_o | output | TAG_W | Tag of early low half |
| lo_sum_o | output | DATA_W/2 | Early low half of result |
| res_valid_o | output | 1 | Full result valid |
| res_dst_o | output | TAG_W | Tag of full result |
| res_sum_o | output | DATA_W | Full 32-bit result |
| res_flags_o | output | 4 | {overflow, sign, carry, zero} |

## Verification
Directed vectors cover a carry that ripples from the low half into the high half, wraps to zero, signed overflow at both ends, and results where only one half is zero. These show whether the cross-half carry and the split zero flag are right. Dependent chains at distance one and two, double matches, disabled bypass and stalls placed between producer and consumer separate a wrong bypass select or a wrong priority from a wrong sum. Random traffic over a small tag space with biased extreme operands mixes all of these with bubbles and stalls.

// File: rtl/stag_pkg.sv
package stag_pkg;

    // Where an operand is taken from
    typedef enum logic [1:0] {
        SRC_PORT = 2'd0,
        SRC_NEAR = 2'd1,
        SRC_FAR  = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic carry;
        logic zero;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    function automatic logic signed_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/stag_src_sel.sv
module stag_src_sel
    import stag_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             byp_en,
    input  logic [TAG_W-1:0] src_tag,
    input  logic             near_valid,
    input  logic [TAG_W-1:0] near_dst,
    input  logic             far_valid,
    input  logic [TAG_W-1:0] far_dst,
    output src_sel_e         sel
);
    always_comb begin
        if (byp_en && near_valid && (near_dst == src_tag)) begin
            sel = SRC_NEAR;
        end else if (byp_en && far_valid && (far_dst == src_tag)) begin
            sel = SRC_FAR;
        end else begin
            sel = SRC_PORT;
        end
    end
endmodule

// File: rtl/stag_lo_phase.sv
module stag_lo_phase #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] b_lo,
    input  logic              sub,
    output logic [HALF_W-1:0] lo,
    output logic              carry,
    output logic              lo_zero
);
    logic [HALF_W-1:0] bx;
    logic [HALF_W:0]   full;

    always_comb begin
        bx      = sub ? ~b_lo : b_lo;
        full    = {1'b0, a_lo} + {1'b0, bx} + {{HALF_W{1'b0}}, sub};
        lo      = full[HALF_W-1:0];
        carry   = full[HALF_W];
        lo_zero = (full[HALF_W-1:0] == '0);
    end
endmodule

// File: rtl/stag_hi_phase.sv
module stag_hi_phase #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] a_hi,
    input  logic [HALF_W-1:0] b_hi,
    input  logic              sub,
    input  logic              cin,
    output logic [HALF_W-1:0] hi,
    output logic              cout,
    output logic              a_msb,
    output logic              bx_msb
);
    logic [HALF_W-1:0] bx;
    logic [HALF_W:0]   full;

    always_comb begin
        bx     = sub ? ~b_hi : b_hi;
        full   = {1'b0, a_hi} + {1'b0, bx} + {{HALF_W{1'b0}}, cin};
        hi     = full[HALF_W-1:0];
        cout   = full[HALF_W];
        a_msb  = a_hi[HALF_W-1];
        bx_msb = bx[HALF_W-1];
    end
endmodule

// File: rtl/stag_flag_phase.sv
module stag_flag_phase
    import stag_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              lo_zero,
    input  logic [HALF_W-1:0] hi,
    input  logic              cout,
    input  logic              a_msb,
    input  logic              bx_msb,
    output flags_t            flags
);
    always_comb begin
        flags.zero  = lo_zero && (hi == '0);
        flags.carry = cout;
        flags.sign  = hi[HALF_W-1];
        flags.ovf   = signed_ovf(a_msb, bx_msb, hi[HALF_W-1]);
    end
endmodule

// File: rtl/stag_adder.sv
module stag_adder
    import stag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall_i,
    input  logic                 issue_valid_i,
    input  logic                 issue_sub_i,
    input  logic [TAG_W-1:0]     issue_dst_i,
    input  logic [DATA_W-1:0]    opa_i,
    input  logic                 opa_byp_i,
    input  logic [TAG_W-1:0]     opa_tag_i,
    input  logic [DATA_W-1:0]    opb_i,
    input  logic                 opb_byp_i,
    input  logic [TAG_W-1:0]     opb_tag_i,
    output logic                 lo_valid_o,
    output logic [TAG_W-1:0]     lo_dst_o,
    output logic [DATA_W/2-1:0]  lo_sum_o,
    output logic                 res_valid_o,
    output logic [TAG_W-1:0]     res_dst_o,
    output logic [DATA_W-1:0]    res_sum_o,
    output logic [3:0]           res_flags_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int N_OPS  = 2;

    typedef struct packed {
        logic              valid;
        logic              sub;
        logic [TAG_W-1:0]  dst;
        logic [HALF_W-1:0] lo;
        logic              c_lo;
        logic              lo_zero;
        logic [HALF_W-1:0] a_hi;
        logic [HALF_W-1:0] b_hi;
        src_sel_e          sel_a;
        src_sel_e          sel_b;
    } ph1_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  dst;
        logic [HALF_W-1:0] lo;
        logic              lo_zero;
        logic [HALF_W-1:0] hi;
        logic              cout;
        logic              a_msb;
        logic              bx_msb;
    } ph2_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  dst;
        logic [DATA_W-1:0] sum;
        flags_t            flags;
    } ph3_t;

    ph1_t s1_q, s1_d;
    ph2_t s2_q, s2_d;
    ph3_t s3_q, s3_d;

    // Per-operand arrays: index 0 = A, 1 = B
    logic              op_byp  [N_OPS];
    logic [TAG_W-1:0]  op_tag  [N_OPS];
    logic [DATA_W-1:0] op_port [N_OPS];
    src_sel_e          sel_now [N_OPS];
    src_sel_e          sel_hld [N_OPS];
    logic [HALF_W-1:0] lo_opnd [N_OPS];
    logic [HALF_W-1:0] hi_port [N_OPS];
    logic [HALF_W-1:0] hi_opnd [N_OPS];

    always_comb begin
        op_byp[0]  = opa_byp_i;
        op_byp[1]  = opb_byp_i;
        op_tag[0]  = opa_tag_i;
        op_tag[1]  = opb_tag_i;
        op_port[0] = opa_i;
        op_port[1] = opb_i;
        sel_hld[0] = s1_q.sel_a;
        sel_hld[1] = s1_q.sel_b;
        hi_port[0] = s1_q.a_hi;
        hi_port[1] = s1_q.b_hi;
    end

    // Bypass selection and half-word operand muxes for both operands
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_opnd
        stag_src_sel #(.TAG_W(TAG_W)) u_sel (
            .byp_en    (op_byp[gi]),
            .src_tag   (op_tag[gi]),
            .near_valid(s1_q.valid),
            .near_dst  (s1_q.dst),
            .far_valid (s2_q.valid),
            .far_dst   (s2_q.dst),
            .sel       (sel_now[gi])
        );

        // Phase 1: low half from producer's phase-1 (near) or phase-2 (far) register
        always_comb begin
            case (sel_now[gi])
                SRC_NEAR: lo_opnd[gi] = s1_q.lo;
                SRC_FAR:  lo_opnd[gi] = s2_q.lo;
                default:  lo_opnd[gi] = op_port[gi][HALF_W-1:0];
            endcase
        end

        // Phase 2: producer has moved one stage on; take its high half
        always_comb begin
            case (sel_hld[gi])
                SRC_NEAR: hi_opnd[gi] = s2_q.hi;
                SRC_FAR:  hi_opnd[gi] = s3_q.sum[DATA_W-1:HALF_W];
                default:  hi_opnd[gi] = hi_port[gi];
            endcase
        end
    end

    // Phase 1 arithmetic
    logic [HALF_W-1:0] p1_lo;
    logic              p1_c;
    logic              p1_z;

    stag_lo_phase #(.HALF_W(HALF_W)) u_lo (
        .a_lo   (lo_opnd[0]),
        .b_lo   (lo_opnd[1]),
        .sub    (issue_sub_i),
        .lo     (p1_lo),
        .carry  (p1_c),
        .lo_zero(p1_z)
    );

    always_comb begin
        s1_d.valid   = issue_valid_i;
        s1_d.sub     = issue_sub_i;
        s1_d.dst     = issue_dst_i;
        s1_d.lo      = p1_lo;
        s1_d.c_lo    = p1_c;
        s1_d.lo_zero = p1_z;
        s1_d.a_hi    = opa_i[DATA_W-1:HALF_W];
        s1_d.b_hi    = opb_i[DATA_W-1:HALF_W];
        s1_d.sel_a   = sel_now[0];
        s1_d.sel_b   = sel_now[1];
    end

    // Phase 2 arithmetic
    logic [HALF_W-1:0] p2_hi;
    logic              p2_c;
    logic              p2_am;
    logic              p2_bm;

    stag_hi_phase #(.HALF_W(HALF_W)) u_hi (
        .a_hi  (hi_opnd[0]),
        .b_hi  (hi_opnd[1]),
        .sub   (s1_q.sub),
        .cin   (s1_q.c_lo),
        .hi    (p2_hi),
        .cout  (p2_c),
        .a_msb (p2_am),
        .bx_msb(p2_bm)
    );

    always_comb begin
        s2_d.valid   = s1_q.valid;
        s2_d.dst     = s1_q.dst;
        s2_d.lo      = s1_q.lo;
        s2_d.lo_zero = s1_q.lo_zero;
        s2_d.hi      = p2_hi;
        s2_d.cout    = p2_c;
        s2_d.a_msb   = p2_am;
        s2_d.bx_msb  = p2_bm;
    end

    // Phase 3 flags
    flags_t p3_flags;

    stag_flag_phase #(.HALF_W(HALF_W)) u_flag (
        .lo_zero(s2_q.lo_zero),
        .hi     (s2_q.hi),
        .cout   (s2_q.cout),
        .a_msb  (s2_q.a_msb),
        .bx_msb (s2_q.bx_msb),
        .flags  (p3_flags)
    );

    always_comb begin
        s3_d.valid = s2_q.valid;
        s3_d.dst   = s2_q.dst;
        s3_d.sum   = {s2_q.hi, s2_q.lo};
        s3_d.flags = p3_flags;
    end

    // Stage registers: one stall freezes all three
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else if (!stall_i) begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign lo_valid_o  = s1_q.valid;
    assign lo_dst_o    = s1_q.dst;
    assign lo_sum_o    = s1_q.lo;
    assign res_valid_o = s3_q.valid;
    assign res_dst_o   = s3_q.dst;
    assign res_sum_o   = s3_q.sum;
    assign res_flags_o = s3_q.flags;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !lo_valid_o && !res_valid_o); // R1

    AST_EARLY_LO: assert property (@(posedge clk) disable iff (rst)
        (lo_valid_o && !stall_i) ##1 !stall_i |=>
            res_valid_o && (res_sum_o[HALF_W-1:0] == $past(lo_sum_o, 2))); // R2

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (res_flags_o[0] == (res_sum_o == '0))); // R6

    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (res_flags_o[2] == res_sum_o[DATA_W-1])); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(res_sum_o) && $stable(res_valid_o) && $stable(res_flags_o)
                    && $stable(lo_sum_o) && $stable(lo_valid_o)); // R12

endmodule

// File: tb/tb_stag_adder.sv
module tb_stag_adder;
    logic        clk = 1'b0;
    logic        rst;
    logic        stall_i;
    logic        issue_valid_i;
    logic        issue_sub_i;
    logic [3:0]  issue_dst_i;
    logic [31:0] opa_i;
    logic        opa_byp_i;
    logic [3:0]  opa_tag_i;
    logic [31:0] opb_i;
    logic        opb_byp_i;
    logic [3:0]  opb_tag_i;
    logic        lo_valid_o;
    logic [3:0]  lo_dst_o;
    logic [15:0] lo_sum_o;
    logic        res_valid_o;
    logic [3:0]  res_dst_o;
    logic [31:0] res_sum_o;
    logic [3:0]  res_flags_o;

    always #5 clk = ~clk;

    stag_adder dut (.*);

    typedef struct packed {
        logic        v;
        logic [3:0]  dst;
        logic [31:0] res;
        logic [3:0]  fl;   // {ovf, sign, carry, zero}
    } slot_t;

    slot_t e1, e2, e3;
    string l1, l2, l3;
    int    nchk  = 0;
    int    nfail = 0;
    bit    done  = 1'b0;

    function automatic slot_t model(logic v, logic sub, logic [3:0] dst, logic [31:0] a, logic [31:0] b);
        slot_t       s;
        logic [31:0] bx;
        logic [32:0] full;
        bx   = sub ? ~b : b;
        full = {1'b0, a} + {1'b0, bx} + {32'd0, sub};
        s.v   = v;
        s.dst = dst;
        s.res = full[31:0];
        s.fl  = {(a[31] == bx[31]) && (full[31] != a[31]), full[31], full[32], full[31:0] == 32'd0};
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic v, logic sub, logic [3:0] dst, logic [31:0] a, logic [31:0] b,
                        logic ea, logic [3:0] ta, logic eb, logic [3:0] tb, logic st, string lb);
        logic [31:0] av, bv;
        slot_t       n;
        string       rl, rs;
        stall_i = st; issue_valid_i = v; issue_sub_i = sub; issue_dst_i = dst;
        opa_i = a; opa_byp_i = ea; opa_tag_i = ta;
        opb_i = b; opb_byp_i = eb; opb_tag_i = tb;
        if (!st) begin
            // R9/R10/R11/R13 operand resolution, nearest slot first
            av = (ea && e1.v && e1.dst == ta) ? e1.res : (ea && e2.v && e2.dst == ta) ? e2.res : a;
            bv = (eb && e1.v && e1.dst == tb) ? e1.res : (eb && e2.v && e2.dst == tb) ? e2.res : b;
            n  = model(v, sub, dst, av, bv);
            e3 = e2; e2 = e1; e1 = n;
            l3 = l2; l2 = l1; l1 = (lb != "") ? lb : (sub ? "R4" : "R3");
        end
        @(posedge clk);
        @(negedge clk);
        rl = st ? "R12" : "R2";
        rs = st ? "R12" : l3;
        chk(rl, {31'd0, lo_valid_o}, {31'd0, e1.v});
        if (e1.v) begin
            chk(rl, {16'd0, lo_sum_o}, {16'd0, e1.res[15:0]});
            chk(rl, {28'd0, lo_dst_o}, {28'd0, e1.dst});
        end
        chk(st ? "R12" : "R3", {31'd0, res_valid_o}, {31'd0, e3.v});
        if (e3.v) begin
            chk(rs, res_sum_o, e3.res);
            chk(rs, {28'd0, res_dst_o}, {28'd0, e3.dst});
            chk("R6", {31'd0, res_flags_o[0]}, {31'd0, e3.fl[0]});
            chk("R5", {31'd0, res_flags_o[1]}, {31'd0, e3.fl[1]});
            chk("R7", {31'd0, res_flags_o[2]}, {31'd0, e3.fl[2]});
            chk("R8", {31'd0, res_flags_o[3]}, {31'd0, e3.fl[3]});
        end
    endtask

    task automatic op(logic sub, logic [3:0] dst, logic [31:0] a, logic [31:0] b,
                      logic ea, logic [3:0] ta, logic eb, logic [3:0] tb, string lb);
        step(1'b1, sub, dst, a, b, ea, ta, eb, tb, 1'b0, lb);
    endtask

    task automatic bubble(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 32'd0, 32'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, "");
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0000_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h0000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        e1 = '0; e2 = '0; e3 = '0; l1 = ""; l2 = ""; l3 = "";
        rst = 1'b1; stall_i = 1'b0; issue_valid_i = 1'b1; issue_sub_i = 1'b0; issue_dst_i = 4'd0;
        opa_i = 32'd0; opa_byp_i = 1'b0; opa_tag_i = 4'd0;
        opb_i = 32'd0; opb_byp_i = 1'b0; opb_tag_i = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", {31'd0, lo_valid_o}, 32'd0);
        chk("R1", {31'd0, res_valid_o}, 32'd0);

        // Arithmetic corners
        op(1'b0, 4'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, "R3");
        op(1'b0, 4'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, "R6");
        op(1'b0, 4'd3, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'd0, 1'b0, 4'd0, "R8");
        op(1'b0, 4'd4, 32'h0001_0000, 32'h0000_0000, 1'b0, 4'd0, 1'b0, 4'd0, "R6");
        op(1'b0, 4'd5, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'd0, 1'b0, 4'd0, "R8");
        op(1'b1, 4'd6, 32'd5, 32'd7, 1'b0, 4'd0, 1'b0, 4'd0, "R4");
        op(1'b1, 4'd7, 32'h1234_0000, 32'h1234_0000, 1'b0, 4'd0, 1'b0, 4'd0, "R4");
        op(1'b1, 4'd8, 32'h8000_0000, 32'd1, 1'b0, 4'd0, 1'b0, 4'd0, "R8");
        bubble(3);

        // R9: back-to-back dependent chain across the half-word carry
        op(1'b0, 4'd1, 32'h0000_FFF0, 32'h0000_0008, 1'b0, 4'd0, 1'b0, 4'd0, "R9");
        op(1'b0, 4'd1, 32'd0, 32'h0000_0010, 1'b1, 4'd1, 1'b0, 4'd0, "R9");
        op(1'b0, 4'd1, 32'd0, 32'hFFFF_0000, 1'b1, 4'd1, 1'b0, 4'd0, "R9");
        op(1'b1, 4'd2, 32'd0, 32'd0, 1'b1, 4'd1, 1'b1, 4'd1, "R9");
        bubble(3);

        // R10: distance two with a bubble between
        op(1'b0, 4'd2, 32'h0001_8000, 32'h0000_8000, 1'b0, 4'd0, 1'b0, 4'd0, "R10");
        bubble(1);
        op(1'b0, 4'd9, 32'd3, 32'd0, 1'b0, 4'd0, 1'b1, 4'd2, "R10");
        bubble(3);

        // R11: both earlier slots match, nearer wins
        op(1'b0, 4'd5, 32'd100, 32'd0, 1'b0, 4'd0, 1'b0, 4'd0, "R11");
        op(1'b0, 4'd5, 32'h0002_00C8, 32'd0, 1'b0, 4'd0, 1'b0, 4'd0, "R11");
        op(1'b0, 4'd10, 32'd1, 32'd0, 1'b0, 4'd0, 1'b1, 4'd5, "R11");
        bubble(3);

        // R12: stall between producer and consumer, junk issue ignored
        op(1'b0, 4'd6, 32'h0003_FFFF, 32'd1, 1'b0, 4'd0, 1'b0, 4'd0, "R12");
        for (int i = 0; i < 3; i++)
            step(1'b1, 1'b1, 4'd6, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, "");
        op(1'b0, 4'd11, 32'd0, 32'd2, 1'b1, 4'd6, 1'b0, 4'd0, "R12");
        bubble(3);

        // R13: bypass disabled or producer is a bubble
        op(1'b0, 4'd3, 32'd50, 32'd50, 1'b0, 4'd0, 1'b0, 4'd0, "R13");
        op(1'b0, 4'd12, 32'd7, 32'd9, 1'b0, 4'd3, 1'b0, 4'd3, "R13");
        step(1'b0, 1'b0, 4'd4, 32'd0, 32'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, "");
        op(1'b0, 4'd13, 32'd11, 32'd0, 1'b1, 4'd4, 1'b0, 4'd0, "R13");
        bubble(3);

        // Random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, $urandom % 2, 4'($urandom % 4), pick(), pick(),
                 $urandom % 2, 4'($urandom % 4), $urandom % 2, 4'($urandom % 4),
                 ($urandom % 10) == 0, "");
        end
        bubble(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule